// File: doc/BRIEF.md
# Transmitter Operating Mode Controller

This block sequences a PLL-based radio transmitter through its power modes. These modes are off, two start-up phases, two transmit phases, clock-only, a register-reset state and two configuration phases. It watches the enable pin, the shared data pin, the oscillator-ready flag and two strobes from the serial configuration loader. The first strobe marks the register as partly loaded and the second marks it as fully loaded. From the loaded configuration it reads the clock-only, modulation-type and clock-output bits. From all of this it drives enables for the crystal oscillator, the PLL, the clock-output driver and the power amplifier.

PLL lock is modelled as a fixed number of reference cycles, counted after the register is loaded and the oscillator is ready. A register-reset path lets software reload the configuration without stopping the oscillator. The path is entered by holding enable low and data high for a minimum number of cycles. Shorter pulses are filtered out. The current mode is exported as a one-hot vector.

Top module: `tx_mode_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, mode_o is 9'b000000001 (off) and all four enables are 0.
- R2: In off, en_i=1 with data_i=0 enters start-up 1 (mode_o bit 1) on the next edge, with the oscillator on and the PLL and amplifier off. Any other input combination leaves the block in off.
- R3: Start-up 1 moves to start-up 2 (bit 2, PLL on, amplifier off) only after cfg_done_i has been seen and xo_ready_i is 1, with clk_only_i=0. It waits in start-up 1 while xo_ready_i is 0.
- R4: Start-up 1 with a loaded register, ready high and clk_only_i=1 enters clock-only (bit 5). In that mode the oscillator is on and the PLL and amplifier are off.
- R5: Start-up 2 lasts exactly LOCK_CYCLES cycles and then moves to a transmit state.
- R6: The transmit state is chosen as follows. With ask_mode_i=0 (FSK), the block goes to amplifier-on transmit (bit 4). With ask_mode_i=1 (ASK), data_i=1 selects bit 4 and data_i=0 selects amplifier-off transmit (bit 3). While en_i=1 the choice follows data_i one edge later.
- R7: en_i=0 with data_i=0 in any mode other than off returns to off on the next edge, with all enables 0.
- R8: en_i=0 with data_i=1 held for RST_CYCLES consecutive edges in any mode other than off enters register reset (bit 6). In that mode the oscillator is on and the PLL and amplifier are off. A shorter pulse leaves the mode unchanged.
- R9: Register reset with en_i=1 and data_i=0 enters config 1 (bit 7). There, cfg_part_i with clk_only_i=0 enters config 2 (bit 8, PLL on). The block moves to transmit LOCK_CYCLES edges after the edge that sampled cfg_done_i.
- R10: Config 1 receiving cfg_done_i with clk_only_i=1 enters clock-only.
- R11: clkdrv_en_o is 1 exactly when the mode is not off and clk_on_cfg_i is 1.
- R12: mode_o is always one-hot. Bit 0 is off, 1 start-up 1, 2 start-up 2, 3 transmit with amplifier off, 4 transmit with amplifier on, 5 clock-only, 6 register reset, 7 config 1, 8 config 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable pin level |
| data_i | input | 1 | Shared serial-data / modulation pin level |
| xo_ready_i | input | 1 | Oscillator amplitude ready |
| cfg_part_i | input | 1 | Strobe: register loaded up to the band bit |
| cfg_done_i | input | 1 | Strobe: register fully loaded |
| clk_only_i | input | 1 | Configuration bit: clock-only operation |
| ask_mode_i | input | 1 | Configuration bit: 1 = ASK, 0 = FSK |
| clk_on_cfg_i | input | 1 | Configuration bit: clock output allowed |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| clkdrv_en_o | output | 1 | Clock-output driver enable |
| pa_en_o | output | 1 | Power amplifier enable |
| mode_o | output | 9 | One-hot current mode |

## Verification
The checks assume the loader strobes are single-cycle pulses that arrive only during a start-up or configuration phase. They also assume that xo_ready_i, once high, stays high while the PLL is counting toward lock. The stimulus raises each strobe for one cycle inside those phases and never drops ready while the controller is powered. Random data toggling is applied only while enable is high, or as deliberate enable-low pulses whose length is chosen below or at the reset minimum.

// File: rtl/tx_mode_pkg.sv
package tx_mode_pkg;
  localparam int unsigned NUM_MODES = 9;

  typedef enum logic [3:0] {
    MODE_OFF    = 4'd0,
    MODE_SU1    = 4'd1,
    MODE_SU2    = 4'd2,
    MODE_TX_QT  = 4'd3,
    MODE_TX_PA  = 4'd4,
    MODE_CLKONL = 4'd5,
    MODE_RREG   = 4'd6,
    MODE_CFG1   = 4'd7,
    MODE_CFG2   = 4'd8
  } mode_e;
endpackage

// File: rtl/tx_mode_timer.sv
module tx_mode_timer #(
  parameter int unsigned LIMIT = 1280
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic hit_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == LAST);

  // counts consecutive run cycles; any gap restarts from zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || hit_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tx_mode_fsm.sv
module tx_mode_fsm
  import tx_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  data_i,
  input  logic  xo_ready_i,
  input  logic  cfg_part_i,
  input  logic  cfg_done_i,
  input  logic  clk_only_i,
  input  logic  ask_mode_i,
  input  logic  lock_hit_i,
  input  logic  rst_hit_i,
  output mode_e state_o,
  output logic  lock_run_o,
  output logic  rst_run_o
);
  mode_e state_q, state_d, tx_pick;
  logic  prog_q;

  assign tx_pick = (ask_mode_i && !data_i) ? MODE_TX_QT : MODE_TX_PA;

  always_comb begin
    state_d = state_q;
    if (state_q != MODE_OFF && !en_i && !data_i) begin
      state_d = MODE_OFF;
    end else if (rst_hit_i) begin
      state_d = MODE_RREG;
    end else begin
      unique case (state_q)
        MODE_OFF:   if (en_i && !data_i) state_d = MODE_SU1;
        MODE_SU1:   if (prog_q && xo_ready_i)
                      state_d = clk_only_i ? MODE_CLKONL : MODE_SU2;
        MODE_SU2,
        MODE_CFG2:  if (lock_hit_i) state_d = tx_pick;
        MODE_TX_QT,
        MODE_TX_PA: if (en_i) state_d = tx_pick;
        MODE_CLKONL: ;
        MODE_RREG:  if (en_i && !data_i) state_d = MODE_CFG1;
        MODE_CFG1: begin
          if (cfg_done_i && clk_only_i)                       state_d = MODE_CLKONL;
          else if ((cfg_part_i || cfg_done_i) && !clk_only_i) state_d = MODE_CFG2;
        end
        default:    state_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_OFF;
      prog_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == MODE_OFF || state_q == MODE_RREG) prog_q <= 1'b0;
      else if (cfg_done_i)                             prog_q <= 1'b1;
    end
  end

  assign state_o    = state_q;
  assign lock_run_o = (state_q == MODE_SU2) || (state_q == MODE_CFG2 && prog_q);
  assign rst_run_o  = !en_i && data_i && state_q != MODE_OFF && state_q != MODE_RREG;
endmodule

// File: rtl/tx_mode_decode.sv
module tx_mode_decode
  import tx_mode_pkg::*;
(
  input  mode_e                  state_i,
  input  logic                   clk_on_cfg_i,
  output logic                   osc_en_o,
  output logic                   pll_en_o,
  output logic                   clkdrv_en_o,
  output logic                   pa_en_o,
  output logic [NUM_MODES-1:0]   mode_o
);
  for (genvar i = 0; i < NUM_MODES; i++) begin : g_hot
    assign mode_o[i] = (state_i == mode_e'(i));
  end

  assign osc_en_o    = (state_i != MODE_OFF);
  assign pll_en_o    = (state_i == MODE_SU2) || (state_i == MODE_CFG2) ||
                       (state_i == MODE_TX_QT) || (state_i == MODE_TX_PA);
  assign pa_en_o     = (state_i == MODE_TX_PA);
  assign clkdrv_en_o = osc_en_o && clk_on_cfg_i;
endmodule

// File: rtl/tx_mode_ctrl.sv
module tx_mode_ctrl
  import tx_mode_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 1280,
  parameter int unsigned RST_CYCLES  = 1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 data_i,
  input  logic                 xo_ready_i,
  input  logic                 cfg_part_i,
  input  logic                 cfg_done_i,
  input  logic                 clk_only_i,
  input  logic                 ask_mode_i,
  input  logic                 clk_on_cfg_i,
  output logic                 osc_en_o,
  output logic                 pll_en_o,
  output logic                 clkdrv_en_o,
  output logic                 pa_en_o,
  output logic [NUM_MODES-1:0] mode_o
);
  mode_e state;
  logic  lock_run, lock_hit, rst_run, rst_hit;

  tx_mode_fsm u_fsm (
    .clk_i, .rst_ni, .en_i, .data_i, .xo_ready_i, .cfg_part_i, .cfg_done_i,
    .clk_only_i, .ask_mode_i,
    .lock_hit_i (lock_hit),
    .rst_hit_i  (rst_hit),
    .state_o    (state),
    .lock_run_o (lock_run),
    .rst_run_o  (rst_run)
  );

  tx_mode_timer #(.LIMIT(LOCK_CYCLES)) u_lock (
    .clk_i, .rst_ni, .run_i(lock_run), .hit_o(lock_hit)
  );

  tx_mode_timer #(.LIMIT(RST_CYCLES)) u_rmin (
    .clk_i, .rst_ni, .run_i(rst_run), .hit_o(rst_hit)
  );

  tx_mode_decode u_dec (
    .state_i (state),
    .clk_on_cfg_i,
    .osc_en_o, .pll_en_o, .clkdrv_en_o, .pa_en_o, .mode_o
  );
endmodule

// File: rtl/tx_mode_ctrl_chk.sv
module tx_mode_ctrl_chk
  import tx_mode_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 data_i,
  input logic                 ask_mode_i,
  input logic                 clk_on_cfg_i,
  input logic                 osc_en_o,
  input logic                 pll_en_o,
  input logic                 clkdrv_en_o,
  input logic                 pa_en_o,
  input logic [NUM_MODES-1:0] mode_o
);
  assert_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_o) == 1);

  assert_pa_needs_pll_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_en_o |-> (pll_en_o && osc_en_o));

  assert_ask_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o[3] || mode_o[4]) && en_i && ask_mode_i && !data_i) |=> !pa_en_o);

  assert_shutdown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o[0] && !en_i && !data_i) |=> (mode_o[0] && !osc_en_o && !clkdrv_en_o));

  assert_rreg_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o[6]) |-> $past(!en_i && data_i));

  assert_rreg_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[6] |-> (osc_en_o && !pll_en_o && !pa_en_o));

  assert_su2_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o[2]) |-> $past(mode_o[1]));

  assert_clkdrv_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkdrv_en_o |-> (clk_on_cfg_i && !mode_o[0]));
endmodule

bind tx_mode_ctrl tx_mode_ctrl_chk u_chk (
  .clk_i, .rst_ni, .en_i, .data_i, .ask_mode_i, .clk_on_cfg_i,
  .osc_en_o, .pll_en_o, .clkdrv_en_o, .pa_en_o, .mode_o
);

// File: tb/sim_tx_mode_ctrl.sv
module sim_tx_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_C     = 1280;
  localparam int RST_C      = 40;
  localparam int WD_LIMIT   = 100000;
  // mode bit positions
  localparam int B_OFF = 0, B_SU1 = 1, B_SU2 = 2, B_TXQ = 3, B_TXP = 4,
                 B_CLK = 5, B_RR = 6, B_CF1 = 7, B_CF2 = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, data = 0, ready = 0, part = 0, done = 0;
  logic conly = 0, ask = 0, clkon = 0;
  logic osc, pll, clkdrv, pa;
  logic [8:0] mode;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_mode_ctrl #(.LOCK_CYCLES(LOCK_C), .RST_CYCLES(RST_C)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .data_i(data), .xo_ready_i(ready),
    .cfg_part_i(part), .cfg_done_i(done), .clk_only_i(conly), .ask_mode_i(ask),
    .clk_on_cfg_i(clkon), .osc_en_o(osc), .pll_en_o(pll), .clkdrv_en_o(clkdrv),
    .pa_en_o(pa), .mode_o(mode)
  );

  function automatic logic [8:0] mv(int idx);
    return 9'(1) << idx;
  endfunction

  function automatic logic exp_pa(logic a, logic d);
    return !a || d;
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_mode(string req, int idx);
    chk(req, 32'(mode), 32'(mv(idx)));
  endtask

  // {osc,pll,pa}
  task automatic chk_en(string req, logic [2:0] exp);
    chk(req, {29'd0, osc, pll, pa}, {29'd0, exp});
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic strobe_done;
    done = 1; tick(); done = 0;
  endtask

  initial begin
    void'($urandom(32'd5821));
    tick(2);
    chk_mode("R1 reset mode", B_OFF);
    chk_en("R1 reset enables", 3'b000);
    chk("R1 clkdrv", 32'(clkdrv), 0);
    rst_n = 1;
    tick();
    chk_mode("R1 after release", B_OFF);

    // R2: off ignores other combinations
    en = 0; data = 1; tick(5);
    chk_mode("R2 off ignores data high", B_OFF);
    en = 1; data = 1; tick(3);
    chk_mode("R2 off ignores en+data high", B_OFF);
    data = 0; tick();
    chk_mode("R2 start-up 1", B_SU1);
    chk_en("R2 su1 enables", 3'b100);

    // R3: wait for ready
    conly = 0; ask = 0; clkon = 1;
    strobe_done();
    tick(4);
    chk_mode("R3 waits for ready", B_SU1);
    chk("R11 clkdrv on in su1", 32'(clkdrv), 1);
    ready = 1; tick();
    chk_mode("R3 start-up 2", B_SU2);
    chk_en("R3 su2 enables", 3'b110);
    tick(LOCK_C - 1);
    chk_mode("R5 still locking", B_SU2);
    tick();
    chk_mode("R5 lock to fsk tx", B_TXP);
    chk_en("R6 fsk amp on", 3'b111);

    // R6: FSK ignores data level
    for (int i = 0; i < 20; i++) begin
      data = 1'($urandom_range(0, 1)); tick();
      chk_mode("R6 fsk random data", B_TXP);
    end

    en = 0; data = 0; tick();
    chk_mode("R7 back to off", B_OFF);
    chk_en("R7 all off", 3'b000);
    chk("R7 clkdrv off", 32'(clkdrv), 0);

    // ASK start-up with clock output disabled
    ask = 1; clkon = 0; en = 1; tick();
    chk_mode("R2 start-up 1 again", B_SU1);
    chk("R11 clkdrv gated by cfg bit", 32'(clkdrv), 0);
    strobe_done();
    tick();
    chk_mode("R3 ready already high", B_SU2);
    tick(LOCK_C - 1);
    chk_mode("R5 still locking ask", B_SU2);
    tick();
    chk_mode("R6 ask data low quiet tx", B_TXQ);
    chk_en("R6 ask amp off", 3'b110);
    for (int i = 0; i < 40; i++) begin
      logic d;
      d = 1'($urandom_range(0, 1));
      data = d; tick();
      chk("R6 ask pa follows data", 32'(pa), 32'(exp_pa(ask, d)));
      chk_mode("R6 ask tx mode", d ? B_TXP : B_TXQ);
    end

    // R8: short pulse ignored
    data = 0; tick();
    en = 0; data = 1; tick(RST_C - 1);
    en = 1; data = 0; tick();
    chk_mode("R8 short pulse ignored", B_TXQ);
    // R8: full pulse
    en = 0; data = 1; tick(RST_C - 1);
    chk("R8 not yet reg reset", 32'(mode[B_RR]), 0);
    tick();
    chk_mode("R8 reg reset", B_RR);
    chk_en("R8 rreg enables", 3'b100);

    // R9: configuration path
    ask = 0; conly = 0;
    en = 1; data = 0; tick();
    chk_mode("R9 config 1", B_CF1);
    chk_en("R9 cfg1 enables", 3'b100);
    part = 1; tick(); part = 0;
    chk_mode("R9 config 2", B_CF2);
    chk_en("R9 cfg2 pll on", 3'b110);
    tick(3);
    chk_mode("R9 waits for full load", B_CF2);
    strobe_done();
    tick(LOCK_C - 1);
    chk_mode("R9 still locking", B_CF2);
    tick();
    chk_mode("R9 transmit after lock", B_TXP);

    // R10: config path to clock-only
    en = 0; data = 1; tick(RST_C);
    chk_mode("R8 reg reset from tx", B_RR);
    en = 1; data = 0; tick();
    chk_mode("R9 config 1 again", B_CF1);
    conly = 1; clkon = 1; strobe_done();
    chk_mode("R10 clock-only", B_CLK);
    chk_en("R10 clock-only enables", 3'b100);
    chk("R11 clkdrv in clock-only", 32'(clkdrv), 1);

    // R8: random short pulses in clock-only
    for (int i = 0; i < 6; i++) begin
      int len;
      len = int'($urandom_range(1, RST_C - 1));
      en = 0; data = 1; tick(len);
      en = 1; data = 0; tick();
      chk_mode("R8 random short pulse", B_CLK);
    end
    for (int i = 0; i < 8; i++) begin
      logic c;
      c = 1'($urandom_range(0, 1));
      clkon = c; tick();
      chk("R11 clkdrv tracks cfg bit", 32'(clkdrv), 32'(c));
    end

    en = 0; data = 0; tick();
    chk_mode("R7 off from clock-only", B_OFF);

    // R4: start-up 1 to clock-only
    en = 1; tick();
    chk_mode("R2 start-up 1 third", B_SU1);
    strobe_done();
    tick();
    chk_mode("R4 clock-only from su1", B_CLK);
    chk_en("R4 clock-only enables", 3'b100);
    en = 0; data = 0; tick();
    chk_mode("R7 final off", B_OFF);

    finished = 1;
    summary();
    $finish;
  end
endmodule